// File: doc/BRIEF.md
# Write Data Interleave Checker

A passive monitor that watches the write address and write data channels of an AXI3 link between one master and one slave. It never drives the bus. Each accepted address is recorded with its ID and burst length in a small shared table. Each accepted data beat is then matched against that table, and the monitor raises sticky error flags, a one-cycle pulse and the ID of the offending transfer.

The beat checks are as follows. The beat's ID must belong to an address that was already accepted. Bursts that share an ID are consumed in the order their addresses arrived. The last-beat marker must fall exactly on the recorded length. The number of bursts that have begun but not finished must stay within a programmable interleaving depth. A serial mode input forbids interleaving altogether, which gives one-burst-at-a-time behaviour.

Top module: `wr_interleave_monitor`

## Requirements
- R1: A synchronous active-high `rst`, or a `clear` pulse in a cycle with no new error, leaves `err_flags`, `err_pulse` and `err_id` at zero on the next edge.
- R2: A transfer counts only on a rising edge where its valid and ready are both high. A data beat with `w_ready` low changes no flag and no tracking state.
- R3: An accepted beat whose `w_id` matches no outstanding address sets `err_flags[0]` (ID mismatch) and is otherwise ignored. This includes data that arrives before its address, and an address accepted on the same edge as the beat does not count.
- R4: A beat with ID X belongs to the oldest outstanding address with ID X. Bursts of one ID are therefore length-checked and retired in address order.
- R5: The burst's last beat must be its beat number `aw_len` (counting from 0). An early or missing `w_last` sets `err_flags[2]` (length). The burst closes on `w_last` or on beat `aw_len`, whichever comes first.
- R6: A beat that opens a new burst while the number of open bursts (started, not closed) is already at least the effective depth sets `err_flags[1]` (depth). The effective depth is `cfg_depth`, and 0 is treated as 1.
- R7: With `cfg_serial` high the effective depth is 1, so a second burst may not start before the open one closes.
- R8: An address accepted while all `NUM_ENT` table slots are occupied sets `err_flags[3]` (overflow) and is dropped.
- R9: `err_pulse` is high for exactly the cycle after the edge on which an error was detected. `err_id` then shows `w_id` for data errors (bits 0 to 2), otherwise `aw_id`, and it holds until the next error or a clear.
- R10: Flags are sticky until `clear` or `rst`. An error detected on the same edge as `clear` is kept.
- R11: With depth 2 or more, interleaving beats of two IDs whose open bursts stay within the depth raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the error outputs |
| cfg_depth | input | DEPTH_W | Allowed number of open write bursts |
| cfg_serial | input | 1 | Forbid interleaving (effective depth 1) |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Burst length minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_id | input | ID_W | Write data ID |
| w_last | input | 1 | Last beat of burst |
| err_flags | output | 4 | Sticky flags: 0 mismatch, 1 depth, 2 length, 3 overflow |
| err_pulse | output | 1 | One-cycle error indication |
| err_id | output | ID_W | ID of the most recent error |

## Verification
The checker is driven with several patterns:
- Two same-ID addresses with different lengths, followed by data. This shows whether beats are mapped to the oldest address, because a wrong mapping turns into a length error.
- Two IDs interleaved within the depth (no error expected), then three IDs opened at depth 2. Together these separate an overly strict depth count from a missing one.
- Serial mode with two IDs.
- Early and missing last beats.
- A table filled to capacity, then a dropped ninth address whose data must mismatch.
- Data on the same edge as its own address.
- An error coinciding with `clear`.

// File: rtl/wim_pkg.sv
package wim_pkg;
  localparam int NUM_ERR      = 4;
  localparam int ERR_MISMATCH = 0;
  localparam int ERR_DEPTH    = 1;
  localparam int ERR_LENGTH   = 2;
  localparam int ERR_OVERFLOW = 3;
endpackage

// File: rtl/wim_slot_table.sv
module wim_slot_table #(
  parameter int ID_W    = 4,
  parameter int LEN_W   = 4,
  parameter int NUM_ENT = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_en,
  input  logic [ID_W-1:0]               alloc_id,
  input  logic [LEN_W-1:0]              alloc_len,
  input  logic                          beat_en,
  input  logic [ID_W-1:0]               beat_id,
  input  logic                          beat_close,
  output logic                          head_hit,
  output logic [LEN_W-1:0]              head_len,
  output logic [LEN_W-1:0]              head_cnt,
  output logic                          full,
  output logic [$clog2(NUM_ENT+1)-1:0]  active_cnt
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CNT_W = $clog2(NUM_ENT + 1);

  logic [NUM_ENT-1:0] vld;
  logic [ID_W-1:0]    id_q   [NUM_ENT];
  logic [LEN_W-1:0]   len_q  [NUM_ENT];
  logic [LEN_W-1:0]   cnt_q  [NUM_ENT];
  logic [IDX_W-1:0]   rank_q [NUM_ENT];

  logic [IDX_W-1:0] free_idx;
  logic             free_found;
  logic [CNT_W-1:0] same_cnt;
  logic             step_en;
  logic             close_same;
  logic [IDX_W-1:0] new_rank;

  // lookup: head of beat ID, first free slot, occupancy per ID, open bursts
  always_comb begin
    head_hit   = 1'b0;
    head_len   = '0;
    head_cnt   = '0;
    full       = 1'b1;
    free_idx   = '0;
    free_found = 1'b0;
    same_cnt   = '0;
    active_cnt = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (vld[i] && id_q[i] == beat_id && rank_q[i] == '0) begin
        head_hit = 1'b1;
        head_len = len_q[i];
        head_cnt = cnt_q[i];
      end
      if (!vld[i]) begin
        full = 1'b0;
        if (!free_found) begin
          free_found = 1'b1;
          free_idx   = IDX_W'(i);
        end
      end
      if (vld[i] && id_q[i] == alloc_id) same_cnt = same_cnt + 1'b1;
      if (vld[i] && cnt_q[i] != '0)      active_cnt = active_cnt + 1'b1;
    end
  end

  assign step_en    = beat_en && head_hit;
  assign close_same = step_en && beat_close && (beat_id == alloc_id);
  assign new_rank   = IDX_W'(same_cnt - CNT_W'(close_same));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (step_en && vld[i] && id_q[i] == beat_id) begin
          if (rank_q[i] == '0) begin
            if (beat_close) vld[i] <= 1'b0;
            else            cnt_q[i] <= cnt_q[i] + 1'b1;
          end else if (beat_close) begin
            rank_q[i] <= rank_q[i] - 1'b1;
          end
        end
        if (alloc_en && !full && free_idx == IDX_W'(i)) begin
          vld[i]    <= 1'b1;
          id_q[i]   <= alloc_id;
          len_q[i]  <= alloc_len;
          cnt_q[i]  <= '0;
          rank_q[i] <= new_rank;
        end
      end
    end
  end
endmodule

// File: rtl/wim_err_latch.sv
module wim_err_latch #(
  parameter int ID_W    = 4,
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [NUM_ERR-1:0] new_err,
  input  logic [ID_W-1:0]    new_id,
  output logic [NUM_ERR-1:0] flags,
  output logic               pulse,
  output logic [ID_W-1:0]    id_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      pulse  <= 1'b0;
      id_out <= '0;
    end else begin
      flags <= (clear ? '0 : flags) | new_err;
      pulse <= |new_err;
      if (|new_err)   id_out <= new_id;
      else if (clear) id_out <= '0;
    end
  end
endmodule

// File: rtl/wr_interleave_monitor.sv
module wr_interleave_monitor #(
  parameter int ID_W    = 4,
  parameter int LEN_W   = 4,
  parameter int NUM_ENT = 8,
  parameter int DEPTH_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic [DEPTH_W-1:0]          cfg_depth,
  input  logic                        cfg_serial,
  input  logic                        aw_valid,
  input  logic                        aw_ready,
  input  logic [ID_W-1:0]             aw_id,
  input  logic [LEN_W-1:0]            aw_len,
  input  logic                        w_valid,
  input  logic                        w_ready,
  input  logic [ID_W-1:0]             w_id,
  input  logic                        w_last,
  output logic [wim_pkg::NUM_ERR-1:0] err_flags,
  output logic                        err_pulse,
  output logic [ID_W-1:0]             err_id
);
  import wim_pkg::*;
  localparam int CNT_W = $clog2(NUM_ENT + 1);

  logic               aw_hs, w_hs;
  logic               head_hit, full;
  logic [LEN_W-1:0]   head_len, head_cnt;
  logic [CNT_W-1:0]   active_cnt;
  logic [DEPTH_W-1:0] eff_depth;
  logic               final_beat, close_now;
  logic [NUM_ERR-1:0] new_err;
  logic [ID_W-1:0]    new_id;

  assign aw_hs = aw_valid && aw_ready;
  assign w_hs  = w_valid && w_ready;

  assign eff_depth  = (cfg_serial || cfg_depth == '0) ? DEPTH_W'(1) : cfg_depth;
  assign final_beat = (head_cnt == head_len);
  assign close_now  = w_last || final_beat;

  wim_slot_table #(.ID_W(ID_W), .LEN_W(LEN_W), .NUM_ENT(NUM_ENT)) u_table (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (aw_hs),
    .alloc_id   (aw_id),
    .alloc_len  (aw_len),
    .beat_en    (w_hs),
    .beat_id    (w_id),
    .beat_close (close_now),
    .head_hit   (head_hit),
    .head_len   (head_len),
    .head_cnt   (head_cnt),
    .full       (full),
    .active_cnt (active_cnt)
  );

  always_comb begin
    new_err               = '0;
    new_err[ERR_MISMATCH] = w_hs && !head_hit;
    new_err[ERR_DEPTH]    = w_hs && head_hit && head_cnt == '0 &&
                            (int'(active_cnt) >= int'(eff_depth));
    new_err[ERR_LENGTH]   = w_hs && head_hit && (w_last != final_beat);
    new_err[ERR_OVERFLOW] = aw_hs && full;
    new_id = (new_err[ERR_MISMATCH] || new_err[ERR_DEPTH] || new_err[ERR_LENGTH])
             ? w_id : aw_id;
  end

  wim_err_latch #(.ID_W(ID_W), .NUM_ERR(NUM_ERR)) u_errs (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .new_err (new_err),
    .new_id  (new_id),
    .flags   (err_flags),
    .pulse   (err_pulse),
    .id_out  (err_id)
  );
endmodule

// File: rtl/wim_monitor_sva.sv
module wim_monitor_sva #(
  parameter int ID_W    = 4,
  parameter int NUM_ERR = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               clear,
  input logic               aw_valid,
  input logic               aw_ready,
  input logic               w_valid,
  input logic               w_ready,
  input logic [NUM_ERR-1:0] err_flags,
  input logic               err_pulse,
  input logic [ID_W-1:0]    err_id
);
  // R9: a pulse always comes with at least one flag raised
  assert_pulse_has_flag_R9: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_flags != '0));

  // R2: with no handshake on either channel nothing can be flagged
  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (!(aw_valid && aw_ready) && !(w_valid && w_ready)) |=> !err_pulse);

  // R10: without clear, no raised flag ever drops
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R1: clear on an idle bus empties the outputs
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (clear && !(aw_valid && aw_ready) && !(w_valid && w_ready))
      |=> (err_flags == '0 && err_id == '0));

  // R9: the reported ID only moves together with a pulse or by clear
  assert_id_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (err_pulse || $stable(err_id)));
endmodule

bind wr_interleave_monitor wim_monitor_sva #(.ID_W(ID_W), .NUM_ERR(wim_pkg::NUM_ERR)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .aw_valid  (aw_valid),
  .aw_ready  (aw_ready),
  .w_valid   (w_valid),
  .w_ready   (w_ready),
  .err_flags (err_flags),
  .err_pulse (err_pulse),
  .err_id    (err_id)
);

// File: tb/wr_interleave_monitor_test.sv
module wr_interleave_monitor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic [3:0] cfg_depth = 4'd2;
  logic       cfg_serial = 1'b0;
  logic       aw_valid = 1'b0, aw_ready = 1'b0;
  logic [3:0] aw_id = '0, aw_len = '0;
  logic       w_valid = 1'b0, w_ready = 1'b0;
  logic [3:0] w_id = '0;
  logic       w_last = 1'b0;
  logic [3:0] err_flags;
  logic       err_pulse;
  logic [3:0] err_id;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [3:0] m_flags = '0;
  logic [3:0] m_id = '0;
  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  wr_interleave_monitor uut (
    .clk(clk), .rst(rst), .clear(clear), .cfg_depth(cfg_depth), .cfg_serial(cfg_serial),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_last(w_last),
    .err_flags(err_flags), .err_pulse(err_pulse), .err_id(err_id)
  );

  // driver: one bus cycle per call; the expected outputs after its edge are queued
  task automatic step(input bit c, input bit awv, input bit awr, input logic [3:0] awid,
                      input logic [3:0] awlen, input bit wv, input bit wr,
                      input logic [3:0] wid, input bit wl, input logic [3:0] emask,
                      input logic [3:0] eid, input string tag);
    @(negedge clk);
    clear = c; aw_valid = awv; aw_ready = awr; aw_id = awid; aw_len = awlen;
    w_valid = wv; w_ready = wr; w_id = wid; w_last = wl;
    m_flags = (c ? 4'h0 : m_flags) | emask;
    if (emask != 4'h0) m_id = eid;
    else if (c)        m_id = 4'h0;
    exp_q.push_back({m_flags, (emask != 4'h0), m_id});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input bit c, input string tag);
    step(c, 0, 0, 0, 0, 0, 0, 0, 0, 4'h0, 0, tag);
  endtask
  task automatic addr(input logic [3:0] id, input logic [3:0] len, input logic [3:0] em,
                      input string tag);
    step(0, 1, 1, id, len, 0, 0, 0, 0, em, id, tag);
  endtask
  task automatic beat(input logic [3:0] id, input bit last, input logic [3:0] em,
                      input string tag);
    step(0, 0, 0, 0, 0, 1, 1, id, last, em, id, tag);
  endtask

  // monitor: compares one queued expectation shortly after each edge
  initial begin
    logic [8:0] e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({err_flags, err_pulse, err_id} !== e) begin
          errors++;
          $display("FAIL %s: flags=%b pulse=%b id=%0d expected flags=%b pulse=%b id=%0d",
                   t, err_flags, err_pulse, err_id, e[8:5], e[4], e[3:0]);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expected completion, run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(0, "R1 reset state");
    // R2: beat offered without ready is not counted
    step(0, 0, 0, 0, 0, 1, 0, 4'd5, 1, 4'h0, 0, "R2 no ready");
    // R3: data with no address
    beat(5, 1, 4'b0001, "R3 unknown id");
    idle(0, "R9 pulse one cycle");
    idle(1, "R1 clear");
    // R4: two same-ID addresses, lengths 1 then 0, retired in order
    addr(1, 1, 0, "R4 addr a");
    addr(1, 0, 0, "R4 addr b");
    beat(1, 0, 0, "R4 first burst beat0");
    beat(1, 1, 0, "R4 first burst last");
    beat(1, 1, 0, "R4 second burst last");
    // R11: interleave two IDs at depth 2
    addr(2, 1, 0, "R11 addr 2");
    addr(3, 1, 0, "R11 addr 3");
    beat(2, 0, 0, "R11 beat 2");
    beat(3, 0, 0, "R11 beat 3");
    beat(2, 1, 0, "R11 last 2");
    beat(3, 1, 0, "R11 last 3");
    // R6: third open burst at depth 2
    addr(4, 1, 0, "R6 addr 4");
    addr(5, 1, 0, "R6 addr 5");
    addr(6, 0, 0, "R6 addr 6");
    beat(4, 0, 0, "R6 open 4");
    beat(5, 0, 0, "R6 open 5");
    beat(6, 1, 4'b0010, "R6 depth exceeded");
    beat(4, 1, 0, "R6 close 4");
    beat(5, 1, 0, "R6 close 5");
    idle(1, "R1 clear after depth");
    // R5: early and missing last
    addr(7, 2, 0, "R5 addr len2");
    beat(7, 1, 4'b0100, "R5 early last");
    addr(7, 0, 0, "R5 addr len0");
    beat(7, 0, 4'b0100, "R5 missing last");
    idle(0, "R10 sticky");
    idle(1, "R1 clear after length");
    cfg_serial = 1'b1;
    // R7: serial mode forbids a second open burst
    addr(8, 1, 0, "R7 addr 8");
    addr(9, 0, 0, "R7 addr 9");
    beat(8, 0, 0, "R7 open 8");
    beat(9, 1, 4'b0010, "R7 second burst");
    beat(8, 1, 0, "R7 close 8");
    idle(1, "R1 clear after serial");
    cfg_serial = 1'b0;
    // R8: overflow of the address table
    for (int i = 0; i < 8; i++) addr(10, 0, 0, "R8 fill");
    addr(11, 0, 4'b1000, "R8 overflow");
    beat(11, 1, 4'b0001, "R8 dropped address");
    for (int i = 0; i < 8; i++) beat(10, 1, 0, "R8 drain");
    idle(1, "R1 clear after overflow");
    // R3: address and data on the same edge
    step(0, 1, 1, 4'd12, 0, 1, 1, 4'd12, 1, 4'b0001, 4'd12, "R3 same edge");
    beat(12, 1, 0, "R3 data after address");
    idle(1, "R1 clear again");
    // R10: error on the clear edge is kept
    step(1, 0, 0, 0, 0, 1, 1, 4'd13, 1, 4'b0001, 4'd13, "R10 error with clear");
    idle(0, "R10 kept");
    idle(0, "R10 still kept");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule